// File: doc/BRIEF.md
# Security Attribution Region Register File

This block holds the software-visible configuration of a processor's security attribution unit: a small enable/control field, a region pointer, a base and a limit word for each implemented region, and a pair of fault registers (a status word and an address word). The address lookup that uses these regions, and the detection of faults, sit in neighbouring logic. That neighbouring logic consumes the stored values and raises fault flags into the status word.

Every bus access carries a security attribute. Only secure-side writes change state. Non-secure reads see zero. Base and limit words are reached indirectly through the region pointer. The pointer only accepts numbers below the implemented region count. Each accepted base or limit update raises a one-cycle invalidate pulse, so that cached lookup results can be discarded. The number of regions is a parameter.

Top module: `sau_region_regs`

## Requirements
- R1: A write with `secAttr` low changes no register and raises no invalidate pulse.
- R2: A read with `secAttr` low returns zero, whatever the word index.
- R3: Word index 0 is the control register. A secure write keeps only bits 1:0 of the data, and reads return zero in bits 31:2.
- R4: Word index 2 is the region pointer. A secure write of a value at or above `REGIONS` is rejected, and the earlier pointer value is kept. Reads return the pointer.
- R5: Word index 3 is the base of the region named by the pointer. A secure write stores the data with bits 4:0 cleared. Other regions keep their values.
- R6: Word index 4 is the limit of the region named by the pointer. A secure write stores the data with bits 4:2 cleared, and bits 1:0 are stored as written.
- R7: `invalidate` is high for exactly the cycle after each clock edge that accepts a base or limit write. It stays low after every other kind of write.
- R8: Word index 5 is the fault status (bits 7:0). Bits set in `faultSet` are set at the next edge. A secure write clears the bits written as one. When a set and a clear hit the same bit at the same edge, the set wins.
- R9: Word index 6 is the fault address. A secure write stores all 32 bits.
- R10: Word index 1 is read-only. It returns `REGIONS` in bits 7:0 and zero above, and writes to it have no effect. Index 7 reads zero.
- R11: After reset, the control, pointer, all base and limit words, status and address all read zero, and `invalidate` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request this cycle |
| secAttr | input | 1 | Access security attribute, 1 = secure |
| wordAddr | input | 3 | Register word index |
| wrData | input | 32 | Write data |
| faultSet | input | 8 | Fault flags to set in the status word |
| rdData | output | 32 | Combinational read data for `wordAddr` |
| invalidate | output | 1 | One-cycle pulse after an accepted base/limit update |

## Verification
The hardest state to reach from the ports is a base or limit word in a region other than the current pointer. Such a word can only be seen after the pointer has been moved away and then moved back. The stimulus fills two regions with distinct patterns and then attempts out-of-range pointer writes in between, so a wrongly accepted pointer would show up as a changed readback. The set-wins collision in the status word is reached by raising `faultSet` in the same cycle as a secure clear of that bit.

// File: rtl/sau_regs_pkg.sv
package sau_regs_pkg;

  // word indices of the register map
  localparam int IDX_CTRL  = 0;
  localparam int IDX_TYPE  = 1;
  localparam int IDX_RNUM  = 2;
  localparam int IDX_BASE  = 3;
  localparam int IDX_LIMIT = 4;
  localparam int IDX_FSTAT = 5;
  localparam int IDX_FADDR = 6;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_TYPE  = 3'd1,
    SEL_RNUM  = 3'd2,
    SEL_BASE  = 3'd3,
    SEL_LIMIT = 3'd4,
    SEL_FSTAT = 3'd5,
    SEL_FADDR = 3'd6,
    SEL_NONE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic ctrlWr;
    logic rnumWr;
    logic baseWr;
    logic limitWr;
    logic fstatWr;
    logic faddrWr;
  } wrStrobe_t;

endpackage

// File: rtl/sau_regs_ctrl.sv
module sau_regs_ctrl
  import sau_regs_pkg::*;
#(
  parameter int REGIONS = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3,
  parameter int RNUM_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              secAttr,
  input  logic [IDX_W-1:0]  wordAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [RNUM_W-1:0] curRnum,
  output wrStrobe_t         strobe,
  output regSel_e           rdSel
);

  localparam logic [DATA_W-1:0] REGION_LIMIT = DATA_W'(REGIONS);

  logic    secWr;
  logic    rnumOk;
  logic    regionOk;
  regSel_e addrSel;

  assign secWr    = wrEn && secAttr;
  assign rnumOk   = wrData < REGION_LIMIT;
  assign regionOk = DATA_W'(curRnum) < REGION_LIMIT;

  always_comb begin
    case (int'(wordAddr))
      IDX_CTRL:  addrSel = SEL_CTRL;
      IDX_TYPE:  addrSel = SEL_TYPE;
      IDX_RNUM:  addrSel = SEL_RNUM;
      IDX_BASE:  addrSel = SEL_BASE;
      IDX_LIMIT: addrSel = SEL_LIMIT;
      IDX_FSTAT: addrSel = SEL_FSTAT;
      IDX_FADDR: addrSel = SEL_FADDR;
      default:   addrSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe = '0;
    if (secWr) begin
      strobe.ctrlWr  = addrSel == SEL_CTRL;
      strobe.rnumWr  = (addrSel == SEL_RNUM) && rnumOk;
      strobe.baseWr  = (addrSel == SEL_BASE) && regionOk;
      strobe.limitWr = (addrSel == SEL_LIMIT) && regionOk;
      strobe.fstatWr = addrSel == SEL_FSTAT;
      strobe.faddrWr = addrSel == SEL_FADDR;
    end
  end

  assign rdSel = secAttr ? addrSel : SEL_NONE;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobe) <= 1); // R1
  AST_NS_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !secAttr |-> (strobe == '0)); // R1

endmodule

// File: rtl/sau_regs_datapath.sv
module sau_regs_datapath
  import sau_regs_pkg::*;
#(
  parameter int REGIONS = 8,
  parameter int DATA_W  = 32,
  parameter int FSTAT_W = 8,
  parameter int RNUM_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobe_t          strobe,
  input  regSel_e            rdSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [FSTAT_W-1:0] faultSet,
  output logic [RNUM_W-1:0]  curRnum,
  output logic [DATA_W-1:0]  rdData,
  output logic               invalidate
);

  localparam logic [DATA_W-1:0] BASE_KEEP  = ~DATA_W'(32'h1F);
  localparam logic [DATA_W-1:0] LIMIT_KEEP = ~DATA_W'(32'h1C);
  localparam logic [DATA_W-1:0] TYPE_VAL   = DATA_W'(8'(REGIONS));

  logic [1:0]         ctrlReg;
  logic [RNUM_W-1:0]  rnumReg;
  logic [FSTAT_W-1:0] fstatReg;
  logic [DATA_W-1:0]  faddrReg;
  logic [DATA_W-1:0]  baseArr  [REGIONS];
  logic [DATA_W-1:0]  limitArr [REGIONS];
  logic [FSTAT_W-1:0] fstatClr;

  assign curRnum  = rnumReg;
  assign fstatClr = strobe.fstatWr ? wrData[FSTAT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      rnumReg    <= '0;
      fstatReg   <= '0;
      faddrReg   <= '0;
      invalidate <= 1'b0;
    end else begin
      if (strobe.ctrlWr)  ctrlReg  <= wrData[1:0];
      if (strobe.rnumWr)  rnumReg  <= wrData[RNUM_W-1:0];
      if (strobe.faddrWr) faddrReg <= wrData;
      fstatReg   <= (fstatReg & ~fstatClr) | faultSet;
      invalidate <= strobe.baseWr || strobe.limitWr;
    end
  end

  for (genvar g = 0; g < REGIONS; g++) begin : g_region
    logic hit;
    assign hit = int'(rnumReg) == g;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseArr[g]  <= '0;
        limitArr[g] <= '0;
      end else begin
        if (strobe.baseWr && hit)  baseArr[g]  <= wrData & BASE_KEEP;
        if (strobe.limitWr && hit) limitArr[g] <= wrData & LIMIT_KEEP;
      end
    end
  end

  always_comb begin
    case (rdSel)
      SEL_CTRL:  rdData = DATA_W'(ctrlReg);
      SEL_TYPE:  rdData = TYPE_VAL;
      SEL_RNUM:  rdData = DATA_W'(rnumReg);
      SEL_BASE:  rdData = baseArr[rnumReg];
      SEL_LIMIT: rdData = limitArr[rnumReg];
      SEL_FSTAT: rdData = DATA_W'(fstatReg);
      SEL_FADDR: rdData = faddrReg;
      default:   rdData = '0;
    endcase
  end

  AST_RNUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(rnumReg) < REGIONS); // R4
  AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    baseArr[rnumReg][4:0] == 5'd0); // R5
  AST_LIMIT_MID_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    limitArr[rnumReg][4:2] == 3'd0); // R6
  AST_FSTAT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fstatWr |=> ((fstatReg & $past(wrData[FSTAT_W-1:0] & ~faultSet)) == '0)); // R8
  AST_FSTAT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (faultSet != '0) |=> ((fstatReg & $past(faultSet)) == $past(faultSet))); // R8

endmodule

// File: rtl/sau_region_regs.sv
module sau_region_regs
  import sau_regs_pkg::*;
#(
  parameter int REGIONS = 8,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3,
  parameter int FSTAT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               secAttr,
  input  logic [IDX_W-1:0]   wordAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [FSTAT_W-1:0] faultSet,
  output logic [DATA_W-1:0]  rdData,
  output logic               invalidate
);

  localparam int RNUM_W = (REGIONS > 1) ? $clog2(REGIONS) : 1;

  wrStrobe_t         strobe;
  regSel_e           rdSel;
  logic [RNUM_W-1:0] curRnum;

  sau_regs_ctrl #(
    .REGIONS(REGIONS), .DATA_W(DATA_W), .IDX_W(IDX_W), .RNUM_W(RNUM_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .secAttr(secAttr),
    .wordAddr(wordAddr), .wrData(wrData), .curRnum(curRnum),
    .strobe(strobe), .rdSel(rdSel)
  );

  sau_regs_datapath #(
    .REGIONS(REGIONS), .DATA_W(DATA_W), .FSTAT_W(FSTAT_W), .RNUM_W(RNUM_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel),
    .wrData(wrData), .faultSet(faultSet), .curRnum(curRnum),
    .rdData(rdData), .invalidate(invalidate)
  );

  AST_NS_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !secAttr |-> (rdData == '0)); // R2
  AST_CTRL_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    (secAttr && int'(wordAddr) == IDX_CTRL) |-> (rdData[DATA_W-1:2] == '0)); // R3
  AST_INVAL_SECURE: assert property (@(posedge clk) disable iff (!rstN)
    invalidate |-> $past(wrEn && secAttr)); // R7

endmodule

// File: tb/tb_sau_region_regs.sv
module tb_sau_region_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        secAttr = 1'b0;
  logic [2:0]  wordAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  faultSet = '0;
  logic [31:0] rdData;
  logic        invalidate;

  int checks = 0;
  int fails  = 0;
  logic lastInval;

  localparam int NREG = 8;

  sau_region_regs #(.REGIONS(NREG)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .secAttr(secAttr),
    .wordAddr(wordAddr), .wrData(wrData), .faultSet(faultSet),
    .rdData(rdData), .invalidate(invalidate)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input logic sec);
    @(negedge clk);
    wrEn = 1'b1; secAttr = sec; wordAddr = 3'(idx); wrData = d;
    @(negedge clk);
    lastInval = invalidate;
    wrEn = 1'b0; secAttr = 1'b0; wrData = '0;
  endtask

  task automatic rd(input string tag, input int idx, input logic sec, input logic [31:0] exp);
    @(negedge clk);
    wrEn = 1'b0; secAttr = sec; wordAddr = 3'(idx);
    #1;
    check(tag, rdData, exp);
    secAttr = 1'b0;
  endtask

  task automatic tReset();
    rd("R11 ctrl", 0, 1'b1, 32'h0);
    rd("R11 rnum", 2, 1'b1, 32'h0);
    rd("R11 base", 3, 1'b1, 32'h0);
    rd("R11 limit", 4, 1'b1, 32'h0);
    rd("R11 fstat", 5, 1'b1, 32'h0);
    rd("R11 faddr", 6, 1'b1, 32'h0);
    check("R11 invalidate", {31'd0, invalidate}, 32'h0);
    rd("R10 type", 1, 1'b1, NREG);
    rd("R10 index7", 7, 1'b1, 32'h0);
  endtask

  task automatic tCtrl();
    wr(0, 32'hFFFF_FFFF, 1'b1);
    check("R7 no pulse on ctrl", {31'd0, lastInval}, 32'h0);
    rd("R3 ctrl all ones", 0, 1'b1, 32'h3);
    wr(0, 32'h0000_0006, 1'b1);
    rd("R3 ctrl masked", 0, 1'b1, 32'h2);
  endtask

  task automatic tType();
    wr(1, 32'h0000_00FF, 1'b1);
    rd("R10 type after write", 1, 1'b1, NREG);
  endtask

  task automatic tRnum();
    wr(2, 32'd5, 1'b1);
    rd("R4 rnum 5", 2, 1'b1, 32'd5);
    wr(2, NREG, 1'b1);
    rd("R4 rnum at limit rejected", 2, 1'b1, 32'd5);
    wr(2, 32'hFFFF_FFFF, 1'b1);
    rd("R4 rnum huge rejected", 2, 1'b1, 32'd5);
    wr(2, NREG - 1, 1'b1);
    rd("R4 rnum top", 2, 1'b1, NREG - 1);
  endtask

  task automatic tRegions();
    wr(2, 32'd2, 1'b1);
    wr(3, 32'h1234_567F, 1'b1);
    check("R7 pulse on base", {31'd0, lastInval}, 32'h1);
    @(negedge clk);
    check("R7 pulse one cycle", {31'd0, invalidate}, 32'h0);
    wr(4, 32'hABCD_EF3F, 1'b1);
    check("R7 pulse on limit", {31'd0, lastInval}, 32'h1);
    rd("R5 base region 2", 3, 1'b1, 32'h1234_5660);
    rd("R6 limit region 2", 4, 1'b1, 32'hABCD_EF23);
    wr(2, 32'd7, 1'b1);
    rd("R5 region 7 untouched", 3, 1'b1, 32'h0);
    wr(3, 32'hFFFF_FFE1, 1'b1);
    wr(4, 32'h0000_1002, 1'b1);
    wr(2, 32'd9, 1'b1);
    rd("R5 base region 7", 3, 1'b1, 32'hFFFF_FFE0);
    rd("R6 limit region 7", 4, 1'b1, 32'h0000_1002);
    wr(2, 32'd2, 1'b1);
    rd("R5 base region 2 kept", 3, 1'b1, 32'h1234_5660);
    rd("R6 limit region 2 kept", 4, 1'b1, 32'hABCD_EF23);
  endtask

  task automatic tNonSecure();
    wr(0, 32'h0, 1'b0);
    rd("R1 ctrl kept", 0, 1'b1, 32'h2);
    wr(2, 32'd0, 1'b0);
    rd("R1 rnum kept", 2, 1'b1, 32'd2);
    wr(3, 32'h0, 1'b0);
    check("R1 no pulse", {31'd0, lastInval}, 32'h0);
    rd("R1 base kept", 3, 1'b1, 32'h1234_5660);
    wr(6, 32'h5555_5555, 1'b0);
    rd("R1 faddr kept", 6, 1'b1, 32'h0);
    rd("R2 ns ctrl", 0, 1'b0, 32'h0);
    rd("R2 ns type", 1, 1'b0, 32'h0);
    rd("R2 ns base", 3, 1'b0, 32'h0);
  endtask

  task automatic tFault();
    @(negedge clk);
    faultSet = 8'hA5;
    @(negedge clk);
    faultSet = 8'h00;
    rd("R8 status set", 5, 1'b1, 32'hA5);
    wr(5, 32'h0000_0005, 1'b0);
    rd("R1 ns clear ignored", 5, 1'b1, 32'hA5);
    wr(5, 32'h0000_0005, 1'b1);
    rd("R8 status cleared", 5, 1'b1, 32'hA0);
    @(negedge clk);
    wrEn = 1'b1; secAttr = 1'b1; wordAddr = 3'd5; wrData = 32'h80; faultSet = 8'h80;
    @(negedge clk);
    wrEn = 1'b0; secAttr = 1'b0; faultSet = 8'h00;
    rd("R8 set wins", 5, 1'b1, 32'hA0);
    wr(6, 32'hDEAD_BEEF, 1'b1);
    rd("R9 fault address", 6, 1'b1, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tCtrl();
    tType();
    tRnum();
    tRegions();
    tNonSecure();
    tFault();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule